// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Cycle

This block is a small single-accumulator processor. Instructions and data share one memory of 16-bit words, and every instruction fits in exactly one word. The processor repeats a fetch and execute loop. It can load the accumulator from memory, add a memory word into it, store it back, halt, and return from an interrupt handler.

All memory traffic passes through an address register and a data buffer register. Both drive a synchronous memory port with one cycle of read latency. After every executed instruction the processor tests its interrupt request line. When a request is pending and interrupts are enabled, it pulses an acknowledge, saves the program counter in a private return register and continues at a fixed handler address. Interrupts stay disabled until the handler executes the return instruction.

The block suits a small supervisory controller that owns a private RAM. It can also serve as a teaching core inside a larger test chip.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and on the first cycle after it, the processor drives address 0x000, write enable low, acknowledge low and halted low. Reset clears the accumulator, sets the program counter to 0x000 and enables interrupts.
- R2: Every instruction word carries its opcode in bits 15:12 and a direct word address in bits 11:0.
- R3: Opcode 0x1 copies the addressed memory word into the accumulator.
- R4: Opcode 0x5 adds the addressed word to the accumulator modulo 2^16, so a carry out of bit 15 is dropped.
- R5: Opcode 0x2 writes the accumulator to the addressed word. Write enable is high for exactly one cycle, with the target address and the data presented in that same cycle.
- R6: The program counter advances by one after each fetch, so instructions run in address order. Any opcode other than 0x0, 0x1, 0x2, 0x5 and 0xB changes neither the accumulator nor memory.
- R7: Opcode 0x0 halts the processor. Once halted, it makes no further writes and raises the halted output. It ignores the interrupt request until the next reset.
- R8: After each instruction, a high interrupt request with interrupts enabled produces a one-cycle acknowledge pulse. It also saves the address of the next instruction and continues fetching at 0x004.
- R9: From interrupt entry onward, further requests are not taken, even if the line stays high, until a return instruction executes.
- R10: Opcode 0xB reloads the saved return address into the program counter and re-enables interrupts.
- R11: Read data is taken from the memory port in the cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rdata | input | 16 | Read data from memory, valid one cycle after the address |
| mem_addr | output | 12 | Registered memory word address |
| mem_wdata | output | 16 | Registered write data |
| mem_we | output | 1 | Registered write enable |
| irq_ack | output | 1 | One-cycle pulse when the interrupt cycle is entered |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The first program is a plain load, unassigned opcode, add and two stores. Its results separate correct operand addressing and in-order sequencing from skipped or repeated instructions. A second sum overflows 16 bits, which shows that the adder wraps rather than saturates or keeps a carry.

An interrupt program holds the request high from reset through the first handler, then raises it again right after a store. The stored words prove three things: the accumulator was captured at the right instruction, the handler was not re-entered while masked, and the return resumed at the correct address.

A last run raises the request only after halt, so that any acknowledge or write would show that a stopped core still responded.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPCODE_W = 4;

  typedef logic [OPCODE_W-1:0] opcode_t;

  localparam opcode_t OPC_HALT  = 4'h0;
  localparam opcode_t OPC_LOAD  = 4'h1;
  localparam opcode_t OPC_STORE = 4'h2;
  localparam opcode_t OPC_ADD   = 4'h5;
  localparam opcode_t OPC_RETI  = 4'hB;

  typedef enum logic [2:0] {
    ST_FETCH   = 3'd0,
    ST_DECODE  = 3'd1,
    ST_OPFETCH = 3'd2,
    ST_EXEC    = 3'd3,
    ST_INTCHK  = 3'd4,
    ST_INTENT  = 3'd5,
    ST_HALT    = 3'd6
  } cpu_state_e;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opcode_t    fetched_op,
  input  logic       irq,
  input  logic       int_en,
  output cpu_state_e state,
  output logic       ack
);

  cpu_state_e state_n;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_FETCH:   state_n = ST_DECODE;
      ST_DECODE: begin
        unique case (fetched_op)
          OPC_LOAD, OPC_ADD: state_n = ST_OPFETCH;
          OPC_STORE:         state_n = ST_EXEC;
          OPC_HALT:          state_n = ST_HALT;
          default:           state_n = ST_INTCHK;
        endcase
      end
      ST_OPFETCH: state_n = ST_EXEC;
      ST_EXEC:    state_n = ST_INTCHK;
      ST_INTCHK:  state_n = (irq && int_en) ? ST_INTENT : ST_FETCH;
      ST_INTENT:  state_n = ST_FETCH;
      ST_HALT:    state_n = ST_HALT;
      default:    state_n = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      ack   <= 1'b0;
    end else begin
      state <= state_n;
      ack   <= (state_n == ST_INTENT);
    end
  end

  // R8: acknowledge never lasts longer than one cycle
  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R7: the halted state is never left without reset
  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |=> (state == ST_HALT));

  // R9: the interrupt cycle is only entered from the check state with enable set
  assert_entry_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INTENT) |-> ($past(state) == ST_INTCHK && $past(int_en)));

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = DATA_W - OPCODE_W,
  parameter int HANDLER_ADDR = 4,
  parameter int RESET_PC     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  cpu_state_e        state,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic              we,
  output logic              int_en
);

  localparam logic [ADDR_W-1:0] HANDLER_PC = ADDR_W'(HANDLER_ADDR);
  localparam logic [ADDR_W-1:0] BOOT_PC    = ADDR_W'(RESET_PC);

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] ret_pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] acc;

  opcode_t           new_op;
  logic [ADDR_W-1:0] new_addr;
  opcode_t           cur_op;

  assign new_op   = rdata[DATA_W-1 -: OPCODE_W];
  assign new_addr = rdata[ADDR_W-1:0];
  assign cur_op   = ir[DATA_W-1 -: OPCODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= BOOT_PC;
      mar    <= BOOT_PC;
      ret_pc <= '0;
      ir     <= '0;
      mbr    <= '0;
      acc    <= '0;
      we     <= 1'b0;
      int_en <= 1'b1;
    end else begin
      unique case (state)
        ST_DECODE: begin
          ir <= rdata;
          pc <= pc + 1'b1;
          unique case (new_op)
            OPC_LOAD, OPC_ADD: mar <= new_addr;
            OPC_STORE: begin
              mar <= new_addr;
              mbr <= acc;
              we  <= 1'b1;
            end
            OPC_RETI: begin
              pc     <= ret_pc;
              int_en <= 1'b1;
            end
            default: ;
          endcase
        end
        ST_EXEC: begin
          we <= 1'b0;
          unique case (cur_op)
            OPC_LOAD: acc <= rdata;
            OPC_ADD:  acc <= acc + rdata;
            default:  ;
          endcase
        end
        ST_INTCHK: mar <= pc;
        ST_INTENT: begin
          ret_pc <= pc;
          pc     <= HANDLER_PC;
          mar    <= HANDLER_PC;
          int_en <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R5: a store drives the write strobe for one cycle only
  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);

  // R5: the write strobe is only seen while the store executes
  assert_we_in_exec_R5: assert property (@(posedge clk) disable iff (rst)
    we |-> (state == ST_EXEC));

  // R10: after a return, the next fetch address is the saved one
  assert_return_target_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && new_op == OPC_RETI) |=> (pc == $past(ret_pc) && int_en));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int HANDLER_ADDR = 4,
  parameter int RESET_PC     = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       irq,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [DATA_W-OPCODE_W-1:0] mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  output logic                       mem_we,
  output logic                       irq_ack,
  output logic                       halted
);

  localparam int ADDR_W = DATA_W - OPCODE_W;

  cpu_state_e state;
  logic       int_en;

  acc_cpu_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fetched_op (mem_rdata[DATA_W-1 -: OPCODE_W]),
    .irq        (irq),
    .int_en     (int_en),
    .state      (state),
    .ack        (irq_ack)
  );

  acc_cpu_dp #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .HANDLER_ADDR (HANDLER_ADDR),
    .RESET_PC     (RESET_PC)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .state  (state),
    .rdata  (mem_rdata),
    .mar    (mem_addr),
    .mbr    (mem_wdata),
    .we     (mem_we),
    .int_en (int_en)
  );

  assign halted = (state == ST_HALT);

  // R8: the cycle after the acknowledge presents the handler address
  assert_handler_entry_R8: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (mem_addr == ADDR_W'(HANDLER_ADDR)));

  // R9: entering the handler masks further requests
  assert_masked_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !int_en);

  // R8: no acknowledge without a request seen the cycle before
  assert_ack_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(irq));

  // R7: a halted core never writes
  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_we && !irq_ack));

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

  localparam int DW = 16;
  localparam int AW = 12;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } wr_item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic          irq_ack;
  logic          halted;

  logic          ld_en   = 1'b0;
  logic [7:0]    ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] tb_mem [256];
  logic [DW-1:0] rd_q;

  int            irq_plan = 0;
  logic          irq_auto;
  logic          ack_prev;
  int            ack_cnt;
  int            n_checks = 0;
  int            n_fail   = 0;
  wr_item_t      exp_q [$];

  always #2 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .irq_ack   (irq_ack),
    .halted    (halted)
  );

  // synchronous memory with one cycle read latency
  always @(posedge clk) begin
    if (ld_en) tb_mem[ld_addr] <= ld_data;
    else if (mem_we) tb_mem[mem_addr[7:0]] <= mem_wdata;
    rd_q <= tb_mem[mem_addr[7:0]];
  end
  assign mem_rdata = rd_q;
  assign irq = irq_auto;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_item_t it;
    it.a = a;
    it.d = d;
    exp_q.push_back(it);
  endtask

  // monitor: scoreboard of writes, acknowledge counting, scripted interrupt line
  always @(negedge clk) begin
    if (rst) begin
      irq_auto <= 1'b0;
      ack_cnt  <= 0;
      ack_prev <= 1'b0;
    end else begin
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk("R5 unexpected write address", {20'h0, mem_addr}, 32'hFFF);
        end else begin
          wr_item_t it;
          it = exp_q.pop_front();
          chk("R5 write address", {20'h0, mem_addr}, {20'h0, it.a});
          chk("R3 R4 R5 write data", {16'h0, mem_wdata}, {16'h0, it.d});
        end
      end
      if (irq_ack) ack_cnt <= ack_cnt + 1;
      if (ack_prev) chk("R8 handler entry address", {20'h0, mem_addr}, 32'h004);
      ack_prev <= irq_ack;
      if (irq_plan == 1) begin
        if (ack_cnt == 0 && !irq_ack) irq_auto <= 1'b1;
        if (mem_addr == 12'h006) irq_auto <= 1'b0;
        if (mem_we && mem_addr == 12'h042) irq_auto <= 1'b1;
      end else if (irq_plan == 2) begin
        if (halted) irq_auto <= 1'b1;
      end
    end
  end

  task automatic ld(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_addr = a;
    ld_data = d;
  endtask

  task automatic start_load(input int plan);
    @(negedge clk);
    rst      = 1'b1;
    irq_plan = 0;
    ld_en    = 1'b1;
    exp_q.delete();
    for (int i = 0; i < 256; i++) ld(8'(i), '0);
    irq_plan = plan;
  endtask

  task automatic release_run;
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int guard = 0;
    while (!halted && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(req, {31'h0, halted}, 32'h1);
    repeat (20) @(negedge clk);
    chk("R7 halted holds", {31'h0, halted}, 32'h1);
    chk("R5 all expected writes seen", exp_q.size(), 32'h0);
  endtask

  initial begin
    // R1: state under reset and on release
    start_load(0);
    ld(8'h00, 16'h1040);
    release_run();
    chk("R1 reset address", {20'h0, mem_addr}, 32'h0);
    chk("R1 reset write enable", {31'h0, mem_we}, 32'h0);
    chk("R1 reset ack", {31'h0, irq_ack}, 32'h0);
    chk("R1 reset halted", {31'h0, halted}, 32'h0);

    // R2 R3 R4 R5 R6: load, unassigned opcode, add, two stores in order
    start_load(0);
    ld(8'h00, 16'h1040);
    ld(8'h01, 16'h7041);
    ld(8'h02, 16'h5041);
    ld(8'h03, 16'h2042);
    ld(8'h04, 16'h2043);
    ld(8'h05, 16'h0000);
    ld(8'h40, 16'h1234);
    ld(8'h41, 16'h1111);
    expect_write(12'h042, 16'h2345);
    expect_write(12'h043, 16'h2345);
    release_run();
    wait_halt("R6 sequential run reaches halt");
    chk("R8 no ack without request", ack_cnt, 32'h0);

    // R4: carry out of bit 15 is dropped
    start_load(0);
    ld(8'h00, 16'h1040);
    ld(8'h01, 16'h5041);
    ld(8'h02, 16'h2042);
    ld(8'h03, 16'h0000);
    ld(8'h40, 16'hFFFF);
    ld(8'h41, 16'h0003);
    expect_write(12'h042, 16'h0002);
    release_run();
    wait_halt("R4 wrap run reaches halt");

    // R8 R9 R10 R11: request from reset, held through handler, raised again after a store
    start_load(1);
    ld(8'h00, 16'h1040);
    ld(8'h01, 16'h5041);
    ld(8'h02, 16'h2042);
    ld(8'h03, 16'h0000);
    ld(8'h04, 16'h2050);
    ld(8'h05, 16'h1040);
    ld(8'h06, 16'hB000);
    ld(8'h40, 16'h0A0A);
    ld(8'h41, 16'h0101);
    expect_write(12'h050, 16'h0A0A);
    expect_write(12'h042, 16'h0B0B);
    expect_write(12'h050, 16'h0B0B);
    release_run();
    wait_halt("R10 return resumes and reaches halt");
    chk("R9 one ack per handler entry", ack_cnt, 32'h2);

    // R7: request raised after halt is ignored
    start_load(2);
    ld(8'h00, 16'h1040);
    ld(8'h01, 16'h2042);
    ld(8'h02, 16'h0000);
    ld(8'h40, 16'h5555);
    expect_write(12'h042, 16'h5555);
    release_run();
    wait_halt("R7 halt reached");
    chk("R7 request while halted not acknowledged", ack_cnt, 32'h0);
    chk("R7 request line seen high", {31'h0, irq}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule